// File: doc/BRIEF.md
# Dual-Mode Systolic Internal Cell

This block is the internal processing element of a trapezoidal systolic array that reduces a compound matrix in two phases. A data word arrives from the cell above, and a multiplier and a swap flag arrive from the cell to the left. The cell combines the incoming word with a value it keeps locally, sends the result downward, and passes the multiplier and swap flag to its right-hand neighbour one clock later.

Two update rules share one multiplier and one adder. While the upper rows of the compound matrix pass through, the cell runs in pivoting mode. In this mode the swap flag, decided by the boundary cell of the same row, can exchange the stored value with the incoming word before the multiply-add. The remaining rows pass through in elimination mode, where the swap flag has no effect. A row counter inside the cell selects the mode. It counts accepted rows since the last clear and changes mode after `TRI_ROWS` rows.

Values are signed Q16.16 fixed point. The product is truncated toward minus infinity to 16 fraction bits. The sum then saturates to the 32-bit range.

Top module: `dual_mode_pe`

## Requirements
- R1: After reset, `valid_o` is 0, `x_out`, `c_out` and `s_out` are 0, `tri_mode_o` is 1, and the stored value is 0.
- R2: In pivoting mode, an accepted row with `s_in`=1 gives `x_out` = sat(p + c_in*x_in) one clock later, and then stores p = x_in.
- R3: In pivoting mode, an accepted row with `s_in`=0 gives `x_out` = sat(x_in + c_in*p) one clock later, and p is unchanged.
- R4: In elimination mode, an accepted row gives `x_out` = sat(x_in + c_in*p) with p unchanged, whatever the value of `s_in`.
- R5: The first `TRI_ROWS` accepted rows after reset or clear use pivoting mode, and every later row uses elimination mode. `tri_mode_o` is 1 exactly while the next accepted row would use pivoting mode, and it is 0 otherwise.
- R6: For an accepted row, `c_out` and `s_out` show `c_in` and `s_in` one clock later.
- R7: `valid_o` is high exactly one clock after an accepted row, meaning `valid_i`=1 with `clear_i`=0. On any other cycle, `valid_o` drops, the data outputs hold their values, and neither p nor the row counter changes.
- R8: The product c*v is formed at full width and shifted right by 16 bits, rounding toward minus infinity. The sum is then clamped to 0x7FFFFFFF or 0x80000000.
- R9: `clear_i` sets p and the row counter to 0 on that clock. An input presented in the same cycle is ignored, and `valid_o` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the stored value and row counter |
| valid_i | input | 1 | Input row present |
| x_in | input | W | Data word from the cell above (Q16.16) |
| c_in | input | W | Multiplier from the left (Q16.16) |
| s_in | input | 1 | Swap flag from the left |
| valid_o | output | 1 | Output row present |
| x_out | output | W | Result word to the cell below |
| c_out | output | W | Registered multiplier to the right |
| s_out | output | 1 | Registered swap flag to the right |
| tri_mode_o | output | 1 | 1 while the cell is in pivoting mode |

## Verification
A wrong stored value is never visible directly. It shows up in the next `x_out` that multiplies p (pivoting with `s_in`=0, or elimination), one clock after that row is accepted. Rows with c = 1.0 and x = 0 therefore expose p at once. A row counter that is off by one shows up on `tri_mode_o` in the same cycle it updates. It also shows up as a wrong `x_out` on the first row after the mode boundary whenever `s_in`=1. Every cycle is compared against an independent model of p and the row count, so a divergence is reported within one clock of the row that causes it.

// File: rtl/dmpe_pkg.sv
package dmpe_pkg;
    localparam int unsigned DATA_W_DEF = 32;
    localparam int unsigned FRAC_W_DEF = 16;
    localparam int unsigned TRI_ROWS_DEF = 4;

    typedef enum logic {
        ROUTE_KEEP = 1'b0,
        ROUTE_SWAP = 1'b1
    } route_e;
endpackage

// File: rtl/dmpe_opsel.sv
module dmpe_opsel #(
    parameter int unsigned W = 32
) (
    input  dmpe_pkg::route_e route_i,
    input  logic [W-1:0]     x_i,
    input  logic [W-1:0]     p_i,
    output logic [W-1:0]     mul_o,
    output logic [W-1:0]     add_o,
    output logic [W-1:0]     p_next_o
);
    always_comb begin
        if (route_i == dmpe_pkg::ROUTE_SWAP) begin
            mul_o    = x_i;
            add_o    = p_i;
            p_next_o = x_i;
        end else begin
            mul_o    = p_i;
            add_o    = x_i;
            p_next_o = p_i;
        end
    end
endmodule

// File: rtl/dmpe_mac.sv
module dmpe_mac #(
    parameter int unsigned W    = 32,
    parameter int unsigned FRAC = 16
) (
    input  logic [W-1:0] c_i,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] y_o
);
    localparam int unsigned PW = 2 * W;
    localparam int unsigned SW = PW + 1;

    logic signed [PW-1:0] prod;
    logic signed [SW-1:0] prod_ext;
    logic signed [SW-1:0] prod_sh;
    logic signed [SW-1:0] sum;
    logic                 in_range;

    always_comb begin
        prod     = $signed(c_i) * $signed(m_i);
        prod_ext = {prod[PW-1], prod};
        prod_sh  = prod_ext >>> FRAC;
        sum      = prod_sh + $signed({{(SW-W){a_i[W-1]}}, a_i});
        in_range = (sum[SW-1:W-1] == '0) || (sum[SW-1:W-1] == '1);
        if (in_range) begin
            y_o = sum[W-1:0];
        end else if (sum[SW-1]) begin
            y_o = {1'b1, {(W-1){1'b0}}};
        end else begin
            y_o = {1'b0, {(W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/dual_mode_pe.sv
module dual_mode_pe #(
    parameter int unsigned W        = dmpe_pkg::DATA_W_DEF,
    parameter int unsigned FRAC     = dmpe_pkg::FRAC_W_DEF,
    parameter int unsigned TRI_ROWS = dmpe_pkg::TRI_ROWS_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         valid_i,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] c_in,
    input  logic         s_in,
    output logic         valid_o,
    output logic [W-1:0] x_out,
    output logic [W-1:0] c_out,
    output logic         s_out,
    output logic         tri_mode_o
);
    localparam int unsigned CNT_W = $clog2(TRI_ROWS + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TRI_ROWS);

    typedef struct packed {
        logic [W-1:0]     p;
        logic [CNT_W-1:0] rows;
        logic [W-1:0]     x;
        logic [W-1:0]     c;
        logic             s;
        logic             vld;
    } state_t;

    state_t state_d, state_q;

    dmpe_pkg::route_e route;
    logic [W-1:0]     mul_op;
    logic [W-1:0]     add_op;
    logic [W-1:0]     p_upd;
    logic [W-1:0]     mac_y;
    logic             pivot_mode;

    assign pivot_mode = (state_q.rows < CNT_LIMIT);
    assign route      = (pivot_mode && s_in) ? dmpe_pkg::ROUTE_SWAP
                                             : dmpe_pkg::ROUTE_KEEP;

    dmpe_opsel #(.W(W)) opsel_i (
        .route_i  (route),
        .x_i      (x_in),
        .p_i      (state_q.p),
        .mul_o    (mul_op),
        .add_o    (add_op),
        .p_next_o (p_upd)
    );

    dmpe_mac #(.W(W), .FRAC(FRAC)) mac_i (
        .c_i (c_in),
        .m_i (mul_op),
        .a_i (add_op),
        .y_o (mac_y)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        if (clear_i) begin
            state_d.p    = '0;
            state_d.rows = '0;
        end else if (valid_i) begin
            state_d.p   = p_upd;
            state_d.x   = mac_y;
            state_d.c   = c_in;
            state_d.s   = s_in;
            state_d.vld = 1'b1;
            if (pivot_mode) begin
                state_d.rows = state_q.rows + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_o    = state_q.vld;
    assign x_out      = state_q.x;
    assign c_out      = state_q.c;
    assign s_out      = state_q.s;
    assign tri_mode_o = pivot_mode;
endmodule

// File: rtl/dmpe_checker.sv
module dmpe_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clear_i,
    input logic         valid_i,
    input logic [W-1:0] c_in,
    input logic         s_in,
    input logic         valid_o,
    input logic [W-1:0] x_out,
    input logic [W-1:0] c_out,
    input logic         s_out,
    input logic         tri_mode_o
);
    p_accept_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clear_i) |=> valid_o);

    p_idle_novalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && !clear_i) |=> !valid_o);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(x_out) && $stable(c_out) && $stable(s_out)));

    p_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clear_i) |=> (c_out == $past(c_in) && s_out == $past(s_in)));

    p_clear_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (tri_mode_o && !valid_o));

    p_mode_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tri_mode_o && !clear_i) |=> !tri_mode_o);
endmodule

bind dual_mode_pe dmpe_checker #(.W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .valid_i    (valid_i),
    .c_in       (c_in),
    .s_in       (s_in),
    .valid_o    (valid_o),
    .x_out      (x_out),
    .c_out      (c_out),
    .s_out      (s_out),
    .tri_mode_o (tri_mode_o)
);

// File: tb/dual_mode_pe_tb_top.sv
module dual_mode_pe_tb_top;
    localparam int unsigned W = 32;
    localparam int unsigned TRI = 4;
    localparam logic [31:0] ONE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] x_in = '0;
    logic [31:0] c_in = '0;
    logic        s_in = 1'b0;
    logic        valid_o;
    logic [31:0] x_out;
    logic [31:0] c_out;
    logic        s_out;
    logic        tri_mode_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] p_m = '0;
    int          rows_m = 0;
    logic [31:0] ex_m = '0;
    logic [31:0] ec_m = '0;
    logic        es_m = 1'b0;

    always #2 clk = ~clk;

    dual_mode_pe #(.W(W), .FRAC(16), .TRI_ROWS(TRI)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .valid_i(valid_i),
        .x_in(x_in), .c_in(c_in), .s_in(s_in), .valid_o(valid_o),
        .x_out(x_out), .c_out(c_out), .s_out(s_out), .tri_mode_o(tri_mode_o)
    );

    function automatic longint raw_mac(logic [31:0] c, logic [31:0] m, logic [31:0] a);
        longint prod;
        prod = longint'($signed(c)) * longint'($signed(m));
        return (prod >>> 16) + longint'($signed(a));
    endfunction

    function automatic logic [31:0] sat32(longint v);
        if (v > longint'(32'sh7FFF_FFFF)) return 32'h7FFF_FFFF;
        if (v < -longint'(64'h8000_0000)) return 32'h8000_0000;
        return v[31:0];
    endfunction

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic clr, input logic s,
                        input logic [31:0] x, input logic [31:0] c);
        string  tag;
        logic   ev;
        longint r;
        @(negedge clk);
        valid_i = v; clear_i = clr; s_in = s; x_in = x; c_in = c;
        ev = 1'b0;
        if (clr) begin
            p_m = '0; rows_m = 0; tag = "R9";
        end else if (v) begin
            ev = 1'b1;
            if (rows_m < TRI && s) begin
                r = raw_mac(c, x, p_m); tag = "R2";
                p_m = x;
            end else if (rows_m < TRI) begin
                r = raw_mac(c, p_m, x); tag = "R3";
            end else begin
                r = raw_mac(c, p_m, x); tag = "R4";
            end
            if (sat32(r) != r[31:0]) tag = "R8";
            ex_m = sat32(r); ec_m = c; es_m = s;
            if (rows_m < TRI) rows_m++;
        end else begin
            tag = "R7";
        end
        @(posedge clk); #1;
        cmp(tag, "valid_o", {31'd0, valid_o}, {31'd0, ev});
        cmp(tag, "x_out", x_out, ex_m);
        cmp("R6", "c_out", c_out, ec_m);
        cmp("R6", "s_out", {31'd0, s_out}, {31'd0, es_m});
        cmp("R5", "tri_mode_o", {31'd0, tri_mode_o}, {31'd0, (rows_m < TRI)});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1;
        cmp("R1", "valid_o", {31'd0, valid_o}, 32'd0);
        cmp("R1", "x_out", x_out, 32'd0);
        cmp("R1", "c_out", c_out, 32'd0);
        cmp("R1", "tri_mode_o", {31'd0, tri_mode_o}, 32'd1);
        @(negedge clk); rst_n = 1'b1;
        // R1: stored value is zero, shown by an elimination-style read in pivot mode
        step(1, 0, 0, 32'h0000_0000, ONE);
        step(1, 1, 0, 32'h0000_0000, ONE);
        // R2/R3: pivot rows with swap and no swap
        step(1, 0, 1, 32'h0003_0000, 32'h0000_8000);
        step(1, 0, 0, 32'h0001_0000, 32'hFFFF_0000);
        step(0, 0, 1, 32'h1234_5678, 32'h1111_1111);
        step(1, 0, 1, 32'hFFFE_8000, 32'h0002_0000);
        step(1, 0, 0, 32'h0000_0000, ONE);
        // R4/R5: elimination, swap flag ignored, p readable with c=1.0, x=0
        step(1, 0, 1, 32'h0000_0000, ONE);
        step(1, 0, 1, 32'h0005_0000, 32'hFFFF_8000);
        // R8: truncation toward minus infinity and saturation
        step(1, 0, 0, 32'h0000_0000, 32'h0000_0001);
        step(1, 1, 0, 32'h0, 32'h0);
        step(1, 0, 1, 32'h7FFF_0000, ONE);
        step(1, 0, 0, 32'h7FFF_0000, ONE);
        step(1, 0, 1, 32'h8000_0000, 32'h0002_0000);
        step(1, 0, 0, 32'h8000_0000, 32'h0003_0000);
        step(1, 0, 0, 32'h0000_0001, 32'hFFFF_FFFF);
        step(1, 0, 0, 32'h0000_0000, ONE);
        // R9: clear during a valid row, then an idle cycle
        step(1, 1, 1, 32'h0009_0000, ONE);
        step(0, 0, 0, 32'h0, 32'h0);
        step(1, 0, 0, 32'h0000_0000, ONE);
        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] x, c;
            logic v, clr, s;
            v   = ($urandom_range(0, 9) < 7);
            clr = ($urandom_range(0, 39) == 0);
            s   = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 9) == 0) begin
                x = $urandom; c = $urandom;
            end else begin
                x = 32'($signed($urandom) >>> 11);
                c = 32'($signed($urandom) >>> 14);
            end
            step(v, clr, s, x, c);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule